// File: doc/BRIEF.md
# HDLC Abort Event Counter

This block watches a serial HDLC receive bit stream, qualified by a per-bit strobe, and counts abort sequences: runs of seven consecutive 1 bits. The count is kept in a saturating counter that a microprocessor reads as two bytes. The first read returns the low byte and clears the counter. The second read returns the upper bits that were captured at the first read. An abort that lands on the clearing read is carried into the fresh count.

Counting stops while any line alarm is raised (loss of signal, out of frame, alarm indication, idle), while the receive controller is disabled, or while the mode qualifier is invalid. When the counter reaches its ceiling it raises a sticky interrupt request. Software clears that request by writing one to it.

Top module: `hdlc_abort_counter`

## Requirements
- R1: An abort is recognised when the bit sampled on the seventh consecutive strobe cycle with `rx_bit_i`=1 is also 1. Cycles with `rx_strobe_i`=0 neither add to the run nor break it.
- R2: After an abort the detector is disarmed until a strobed 0 bit arrives. A run of 1s of any length counts as a single abort.
- R3: Each counted abort raises the counter by exactly one. After reset the counter is 0.
- R4: The counter is `CNT_W` bits wide and stays at 2^CNT_W-1 when further aborts arrive, without wrapping.
- R5: While `rd_lo_i` is high, `rd_data_o` shows count bits [7:0] in the same cycle. The counter is cleared at the clock edge that ends that cycle. `rd_lo_i` has priority over `rd_hi_i`.
- R6: While `rd_hi_i` is high and `rd_lo_i` is low, `rd_data_o` shows count bits [CNT_W-1:8] as they stood at the last low-byte read, zero-extended. With neither read strobe high, `rd_data_o` is 0.
- R7: An abort recognised in the same cycle as a low-byte read is not lost: the count after the clear is 1.
- R8: While any of `los_i`, `oof_i`, `ais_i`, `idle_i` is high, a recognised abort does not change the count.
- R9: While `ctrl_en_i` or `mode_ok_i` is low, a recognised abort does not change the count.
- R10: `sat_irq_o` rises on the edge at which the counter reaches 2^CNT_W-1 through a counted abort. It stays high through later reads and aborts.
- R11: `sat_clr_i` high for one cycle clears `sat_irq_o`. If it coincides with the saturating abort, the flag is set.
- R12: After reset `sat_irq_o` is 0 and the holding register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Serial receive bit |
| rx_strobe_i | input | 1 | Marks the cycle in which `rx_bit_i` is valid |
| ctrl_en_i | input | 1 | Receive controller enable |
| mode_ok_i | input | 1 | Mode qualifier; count only when high |
| los_i | input | 1 | Loss of signal alarm |
| oof_i | input | 1 | Out of frame alarm |
| ais_i | input | 1 | Alarm indication signal |
| idle_i | input | 1 | Idle signal alarm |
| rd_lo_i | input | 1 | Low-byte read strobe; snapshots and clears |
| rd_hi_i | input | 1 | High-byte read strobe |
| sat_clr_i | input | 1 | Write-one-to-clear of the saturation flag |
| rd_data_o | output | BYTE_W | Read data |
| sat_irq_o | output | 1 | Sticky saturation interrupt request |

## Verification
Saturation and the collision between the saturating abort and a flag clear are the hardest states to reach. With a 16-bit counter that needs tens of thousands of aborts. The bench therefore builds the block with a 10-bit counter, so 1023 aborts reach the ceiling. It drives that many sequences back to back, then puts a clear on exactly the strobe cycle that completes abort 1023. The abort that collides with a low-byte read is placed the same way: six 1 bits first, then the seventh on the read cycle. Random biased streams with sparse alarms and reads are checked against a bench model.

// File: rtl/abort_cnt_pkg.sv
package abort_cnt_pkg;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 16;
  localparam int unsigned RUN_LEN_DEF = 7;

  function automatic logic any_alarm(input logic [3:0] alarms);
    return |alarms;
  endfunction
endpackage

// File: rtl/abort_detect.sv
module abort_detect #(
  parameter int unsigned RUN_LEN = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic strobe_i,
  output logic hit_o
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] TOP = RW'(RUN_LEN - 1);

  logic [RW-1:0] run_q;
  logic          armed_q;

  assign hit_o = strobe_i & bit_i & armed_q & (run_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      armed_q <= 1'b1;
    end else if (strobe_i) begin
      if (!bit_i) begin
        run_q   <= '0;
        armed_q <= 1'b1;
      end else if (hit_o) begin
        armed_q <= 1'b0;  // wait for a 0 before rearming
      end else if (run_q != TOP) begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/abort_accum.sv
module abort_accum #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reach_o
);
  localparam logic [CNT_W-1:0] MAX    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MAX_M1 = MAX - 1'b1;

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o   = cnt_q;
  assign reach_o = inc_i & ~clr_i & (cnt_q == MAX_M1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= {{(CNT_W-1){1'b0}}, inc_i};  // keep an event landing on the read
    end else if (inc_i && cnt_q != MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/byte_read_port.sv
module byte_read_port #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CNT_W-BYTE_W-1:0] hold_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  logic [HI_W-1:0] hold_q;

  assign hold_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (rd_lo_i) hold_q <= cnt_i[CNT_W-1:BYTE_W];
  end

  always_comb begin
    if (rd_lo_i)      data_o = cnt_i[BYTE_W-1:0];
    else if (rd_hi_i) data_o = BYTE_W'(hold_q);
    else              data_o = '0;
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/hdlc_abort_counter.sv
module hdlc_abort_counter
  import abort_cnt_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned BYTE_W  = BYTE_W_DEF,
  parameter int unsigned RUN_LEN = RUN_LEN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_bit_i,
  input  logic              rx_strobe_i,
  input  logic              ctrl_en_i,
  input  logic              mode_ok_i,
  input  logic              los_i,
  input  logic              oof_i,
  input  logic              ais_i,
  input  logic              idle_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic              sat_clr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              sat_irq_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  logic             hit_w;
  logic             count_ok_w;
  logic             inc_w;
  logic             reach_w;
  logic [CNT_W-1:0] cnt_w;
  logic [HI_W-1:0]  hold_w;

  assign count_ok_w = ctrl_en_i & mode_ok_i & ~any_alarm({los_i, oof_i, ais_i, idle_i});
  assign inc_w      = hit_w & count_ok_w;

  abort_detect #(.RUN_LEN(RUN_LEN)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_i    (rx_bit_i),
    .strobe_i (rx_strobe_i),
    .hit_o    (hit_w)
  );

  abort_accum #(.CNT_W(CNT_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc_w),
    .clr_i   (rd_lo_i),
    .cnt_o   (cnt_w),
    .reach_o (reach_w)
  );

  byte_read_port #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rdport (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_lo_i (rd_lo_i),
    .rd_hi_i (rd_hi_i),
    .cnt_i   (cnt_w),
    .hold_o  (hold_w),
    .data_o  (rd_data_o)
  );

  sticky_flag u_sat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (reach_w),
    .clr_i  (sat_clr_i),
    .flag_o (sat_irq_o)
  );
endmodule

// File: rtl/hdlc_abort_counter_chk.sv
module hdlc_abort_counter_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ctrl_en_i,
  input logic                    mode_ok_i,
  input logic                    los_i,
  input logic                    oof_i,
  input logic                    ais_i,
  input logic                    idle_i,
  input logic                    rd_lo_i,
  input logic                    rd_hi_i,
  input logic                    sat_clr_i,
  input logic [BYTE_W-1:0]       rd_data_o,
  input logic                    sat_irq_o,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [CNT_W-BYTE_W-1:0] hold_q
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX) && !rd_lo_i |=> cnt_q == MAX);

  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> cnt_q <= 1);

  // R6
  hold_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> hold_q == $past(cnt_q[CNT_W-1:BYTE_W]));

  // R6
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_lo_i && !rd_hi_i |-> rd_data_o == '0);

  // R8
  alarm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (los_i || oof_i || ais_i || idle_i) && !rd_lo_i |=> $stable(cnt_q));

  // R9
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en_i || !mode_ok_i) && !rd_lo_i |=> $stable(cnt_q));

  // R10
  sat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_irq_o && !sat_clr_i |=> sat_irq_o);

  // R10
  sat_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_irq_o) |-> cnt_q == MAX);
endmodule

bind hdlc_abort_counter hdlc_abort_counter_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_en_i (ctrl_en_i),
  .mode_ok_i (mode_ok_i),
  .los_i     (los_i),
  .oof_i     (oof_i),
  .ais_i     (ais_i),
  .idle_i    (idle_i),
  .rd_lo_i   (rd_lo_i),
  .rd_hi_i   (rd_hi_i),
  .sat_clr_i (sat_clr_i),
  .rd_data_o (rd_data_o),
  .sat_irq_o (sat_irq_o),
  .cnt_q     (cnt_w),
  .hold_q    (hold_w)
);

// File: tb/hdlc_abort_counter_tb.sv
`timescale 1ns/100ps
module hdlc_abort_counter_tb;
  localparam int unsigned CNT_W  = 10;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HI_W   = CNT_W - BYTE_W;
  localparam int unsigned MAXV   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0, rx_stb = 1'b0;
  logic ctrl_en = 1'b1, mode_ok = 1'b1;
  logic los = 1'b0, oof = 1'b0, ais = 1'b0, idle = 1'b0;
  logic rd_lo = 1'b0, rd_hi = 1'b0, sat_clr = 1'b0;
  logic [BYTE_W-1:0] rd_data;
  logic sat_irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // bench model
  int m_run = 0;
  bit m_armed = 1'b1;
  int m_cnt = 0;
  int m_hold = 0;
  bit m_sat = 1'b0;

  always #2.5 clk = ~clk;

  hdlc_abort_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .rx_strobe_i(rx_stb),
    .ctrl_en_i(ctrl_en), .mode_ok_i(mode_ok), .los_i(los), .oof_i(oof),
    .ais_i(ais), .idle_i(idle), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .sat_clr_i(sat_clr), .rd_data_o(rd_data), .sat_irq_o(sat_irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int exp_data(input bit lo, input bit hi);
    if (lo) return m_cnt & 8'hFF;
    if (hi) return m_hold;
    return 0;
  endfunction

  function automatic bit gate_open();
    return ctrl_en && mode_ok && !los && !oof && !ais && !idle;
  endfunction

  // one clock: drive, check read data, advance model, release strobes
  task automatic drive(input bit b, input bit s, input bit lo, input bit hi,
                       input bit clr, output int data);
    bit hit, inc;
    @(negedge clk);
    rx_bit = b; rx_stb = s; rd_lo = lo; rd_hi = hi; sat_clr = clr;
    #1;
    data = int'(rd_data);
    if (lo || hi) check(lo ? "R5" : "R6", data, exp_data(lo, hi));
    hit = s && b && m_armed && (m_run == 6);
    inc = hit && gate_open();
    if (s) begin
      if (!b) begin m_run = 0; m_armed = 1'b1; end
      else if (hit) m_armed = 1'b0;
      else if (m_run != 6) m_run++;
    end
    if (inc && !lo && m_cnt == MAXV - 1) m_sat = 1'b1;
    else if (clr) m_sat = 1'b0;
    if (lo) begin
      m_hold = m_cnt >> BYTE_W;
      m_cnt = inc ? 1 : 0;
    end else if (inc && m_cnt != MAXV) m_cnt++;
    @(posedge clk);
    #1;
    rx_stb = 1'b0; rd_lo = 1'b0; rd_hi = 1'b0; sat_clr = 1'b0;
  endtask

  task automatic bits(input bit b, input int n);
    int d;
    for (int i = 0; i < n; i++) drive(b, 1'b1, 1'b0, 1'b0, 1'b0, d);
  endtask

  task automatic aborts(input int n);
    for (int i = 0; i < n; i++) begin bits(1'b1, 7); bits(1'b0, 1); end
  endtask

  task automatic read_lo(output int v);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, v);
  endtask

  task automatic read_hi(output int v);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, v);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 check("R12", int'(sat_irq), 0);
    check("R6", int'(rd_data), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    read_lo(v); check("R3", v, 0);
    read_hi(v); check("R12", v, 0);

    // R1 / R3: single abort, then two
    aborts(1);
    read_lo(v); check("R1", v, 1);
    aborts(2);
    read_lo(v); check("R3", v, 2);

    // R2: long run counts once
    bits(1'b1, 25); bits(1'b0, 1);
    read_lo(v); check("R2", v, 1);

    // R1: six ones are not an abort
    bits(1'b1, 6); bits(1'b0, 1); bits(1'b1, 6); bits(1'b0, 1);
    read_lo(v); check("R1", v, 0);

    // R1: unstrobed cycles neither extend nor break the run
    bits(1'b1, 3);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, v);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, v);
    bits(1'b1, 4); bits(1'b0, 1);
    read_lo(v); check("R1", v, 1);

    // R8: each alarm blocks counting
    for (int a = 0; a < 4; a++) begin
      los = (a == 0); oof = (a == 1); ais = (a == 2); idle = (a == 3);
      aborts(1);
      los = 0; oof = 0; ais = 0; idle = 0;
      read_lo(v); check("R8", v, 0);
    end

    // R9: controller disabled / mode invalid
    ctrl_en = 1'b0; aborts(1); ctrl_en = 1'b1;
    read_lo(v); check("R9", v, 0);
    mode_ok = 1'b0; aborts(2); mode_ok = 1'b1;
    read_lo(v); check("R9", v, 0);

    // R7: abort coincides with the clearing read
    aborts(2);
    bits(1'b1, 6);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, v); check("R7", v, 2);
    bits(1'b0, 1);
    read_lo(v); check("R7", v, 1);

    // R6: high byte is the snapshot, not the live count
    aborts(300);
    read_lo(v); check("R5", v, 300 & 8'hFF);
    aborts(1);
    read_hi(v); check("R6", v, 1);
    read_hi(v); check("R6", v, 1);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, v); check("R5", v, 1);
    check("R6", int'(rd_data), 0);

    // R4 / R10 / R11: saturation
    aborts(1022);
    check("R10", int'(sat_irq), 0);
    aborts(1);
    check("R10", int'(sat_irq), 1);
    aborts(3);
    read_lo(v); check("R4", v, 8'hFF);
    read_hi(v); check("R4", v, 3);
    check("R10", int'(sat_irq), 1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, v);
    check("R11", int'(sat_irq), 0);
    aborts(1022);
    bits(1'b1, 6);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, v);
    check("R11", int'(sat_irq), 1);
    bits(1'b0, 1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, v);
    check("R11", int'(sat_irq), 0);
    read_lo(v); check("R4", v, 8'hFF);

    // random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      bit b, s, lo, hi, clr;
      b   = ($urandom % 100) < 88;
      s   = ($urandom % 100) < 80;
      lo  = ($urandom % 100) < 3;
      hi  = ($urandom % 100) < 3;
      clr = ($urandom % 100) < 2;
      if (($urandom % 100) < 2) los = ~los;
      if (($urandom % 100) < 2) oof = ~oof;
      if (($urandom % 100) < 1) ais = ~ais;
      if (($urandom % 100) < 1) idle = ~idle;
      if (($urandom % 100) < 1) ctrl_en = ~ctrl_en;
      if (($urandom % 100) < 1) mode_ok = ~mode_ok;
      drive(b, s, lo, hi, clr, v);
      if (i % 8 == 0) check("R10", int'(sat_irq), int'(m_sat));
    end
    los = 0; oof = 0; ais = 0; idle = 0; ctrl_en = 1; mode_ok = 1;
    read_lo(v);
    read_hi(v);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule